// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from eight software-raised sources and a parameterized group of peripheral request lines, and presents one request to a processor. Each request arrives with the 9-bit vector that identifies its source. Every source carries a programmable 4-bit priority. The controller selects the highest-priority pending source. It forwards that source only when its priority is strictly above a programmable current-priority value, so that the running handler can only be interrupted by something more urgent.

Software raises a software source with a write-one-to-set bit and lowers it with a separate write-one-to-clear bit. The sources' priorities and the current priority are held in a small word-addressed register file. Requests pass through a fixed pipeline. A peripheral line reaches the processor output three clocks after it rises. A software source reaches the output four clocks after the cycle of the write that sets it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When a peripheral input first goes high and that source wins, `irq_o` goes high exactly three rising edges later. When the input falls, `irq_o` goes low exactly three edges later.
- R2: When a write sets a software source and that source wins, `irq_o` goes high on the fourth rising edge, counting the edge that takes the write as the first.
- R3: Software control words are at address 0 (sources 0–3) and address 1 (sources 4–7), with one byte per source and the lowest source in the low byte. In each byte, bit 1 is SET and bit 0 is CLR. Writing 1 to SET raises the pending flag. Writing 1 to CLR lowers it. Writing 0 to either bit leaves the flag as it was. Writing 1 to both leaves the flag set. On a read, bit 0 returns the flag and bit 1 returns 0.
- R4: Software source i carries vector i. Peripheral input j carries vector 8+j.
- R5: Among the pending sources, the one with the numerically largest priority wins.
- R6: When pending sources share the largest priority, the one with the lowest vector wins.
- R7: A winner is forwarded only when its priority is strictly greater than the current priority. A source with priority 0 is never forwarded.
- R8: The current priority is at address 2, bits 3:0. A write to it takes effect on `irq_o` at the second rising edge, counting the write edge as the first.
- R9: `irq_vec_o` does not change while `irq_o` stays high. When a different source takes over, `irq_o` drops for exactly one cycle and then returns with the new vector. With a peripheral source, the drop comes three edges after the new input rises.
- R10: After reset, `irq_o` is low, all flags are clear, and all priorities and the current priority read as 0.
- R11: The priority of source s is at address 4 + s/4, in bits 3:0 of byte s mod 4. Bits 7:4 of each byte are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req_i | input | N_PERIPH | Level requests from peripherals; bit j uses vector 8+j |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for both read and write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data at `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | 9 | Vector of the forwarded source |

## Verification
A fault in the request pipeline shows up as `irq_o` rising or falling one edge early or late. The bench therefore samples the exact edge both before and after each expected change. A wrong winner, whether from a priority compare or from tie ordering, appears as a wrong vector within four clocks of the requests settling. A stale flag or priority register shows up on the next read, and again on the following request. A bad vector hand-over shows up as the vector moving while `irq_o` stays high, or as a missing or extra gap cycle three edges after the new source rises.

// File: rtl/prio_irq_pkg.sv
// Shared constants and types for the prioritized interrupt controller.
// Assumes at most 2**VEC_W sources; the address map is fixed by the constants below.
package prio_irq_pkg;
    localparam int SW_SRC    = 8;
    localparam int VEC_W     = 9;
    localparam int PRIO_W    = 4;
    localparam int REG_W     = 32;
    localparam int A_SW_BASE = 0;
    localparam int A_CUR     = 2;
    localparam int A_PRIO    = 4;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } win_t;
endpackage

// File: rtl/prio_irq_regs.sv
// Register file: software pending flags (set wins over clear), per-source
// priorities and the current priority. Read data is combinational on addr_i.
// Assumes ADDR_W can address A_PRIO + ceil(N_SRC/4) words.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [REG_W-1:0]              wr_data_i,
    output logic [REG_W-1:0]              rd_data_o,
    output logic [SW_SRC-1:0]             sw_flag_o,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [PRIO_W-1:0]             cur_prio_o
);
    localparam int PRIO_WORDS = (N_SRC + 3) / 4;
    localparam int SW_WORDS   = SW_SRC / 4;

    logic [SW_SRC-1:0]            flag_q;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]            cur_q;

    for (genvar s = 0; s < SW_SRC; s++) begin : g_flag
        localparam int BYTE = s % 4;
        logic hit;
        assign hit = wr_en_i && (addr_i == ADDR_W'(A_SW_BASE + s / 4));
        // Pending flag of one software source: SET beats CLR, zeros do nothing.
        always_ff @(posedge clk) begin
            if (!rst_n)                               flag_q[s] <= 1'b0;
            else if (hit && wr_data_i[BYTE*8 + 1])    flag_q[s] <= 1'b1;
            else if (hit && wr_data_i[BYTE*8])        flag_q[s] <= 1'b0;
        end
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_prio
        localparam int BYTE = s % 4;
        logic hit;
        assign hit = wr_en_i && (addr_i == ADDR_W'(A_PRIO + s / 4));
        // Priority of one source, low nibble of its byte.
        always_ff @(posedge clk) begin
            if (!rst_n)   prio_q[s] <= '0;
            else if (hit) prio_q[s] <= wr_data_i[BYTE*8 +: PRIO_W];
        end
    end

    // Current-priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          cur_q <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(A_CUR))        cur_q <= wr_data_i[PRIO_W-1:0];
    end

    // Read mux over all words; unmapped bits read 0.
    always_comb begin
        rd_data_o = '0;
        for (int w = 0; w < SW_WORDS; w++)
            if (addr_i == ADDR_W'(A_SW_BASE + w))
                for (int b = 0; b < 4; b++) rd_data_o[b*8] = flag_q[w*4 + b];
        if (addr_i == ADDR_W'(A_CUR)) rd_data_o[PRIO_W-1:0] = cur_q;
        for (int w = 0; w < PRIO_WORDS; w++)
            if (addr_i == ADDR_W'(A_PRIO + w))
                for (int b = 0; b < 4; b++)
                    if (w*4 + b < N_SRC) rd_data_o[b*8 +: PRIO_W] = prio_q[w*4 + b];
    end

    assign sw_flag_o  = flag_q;
    assign prio_o     = prio_q;
    assign cur_prio_o = cur_q;

    // R3
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(A_SW_BASE) && wr_data_i[1]) |=> flag_q[0]);
endmodule

// File: rtl/prio_irq_arb.sv
// Registered arbiter: picks the pending source with the largest priority,
// lowest index on ties; priority 0 never wins. One pipeline stage.
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
    output win_t                          win_o
);
    win_t best;

    // Linear scan; strict compare keeps the lowest index on equal priority.
    always_comb begin
        best = '0;
        for (int i = 0; i < N_SRC; i++)
            if (req_i[i] && prio_i[i] > best.prio) begin
                best.prio = prio_i[i];
                best.vec  = VEC_W'(i);
            end
        best.valid = (best.prio != '0);
    end

    // Winner register.
    always_ff @(posedge clk) begin
        if (!rst_n) win_o <= '0;
        else        win_o <= best;
    end

    // R5
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_o.valid |-> |($past(req_i) & (N_SRC'(1) << win_o.vec)));
endmodule

// File: rtl/prio_irq_issue.sv
// Output stage: forwards the winner when it beats the current priority and
// keeps the vector fixed while the request is high (one-cycle gap on hand-over).
module prio_irq_issue
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  win_t              win_i,
    input  logic [PRIO_W-1:0] cur_prio_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic go;
    assign go = win_i.valid && (win_i.prio > cur_prio_i);

    // Request/vector register with hand-over gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else if (irq_o && go && win_i.vec != vec_o) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= go;
            if (go) vec_o <= win_i.vec;
        end
    end

    // R9
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> $stable(vec_o));
    // R7
    beats_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(win_i.prio > cur_prio_i));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: registers all requests (software flags low, peripherals above), then
// arbitration, then the output stage. Peripheral path 3 clocks, software 4.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_PERIPH = 8,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] periph_req_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [31:0]         wr_data_i,
    output logic [31:0]         rd_data_o,
    output logic                irq_o,
    output logic [8:0]          irq_vec_o
);
    localparam int N_SRC = SW_SRC + N_PERIPH;

    logic [SW_SRC-1:0]            sw_flag;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;
    logic [PRIO_W-1:0]            cur_prio;
    logic [N_SRC-1:0]             req_q;
    win_t                         win;

    prio_irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .sw_flag_o(sw_flag),
        .prio_o(prio), .cur_prio_o(cur_prio)
    );

    // Request capture stage shared by both source kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= {periph_req_i, sw_flag};
    end

    prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req_q), .prio_i(prio), .win_o(win)
    );

    prio_irq_issue u_issue (
        .clk(clk), .rst_n(rst_n), .win_i(win), .cur_prio_i(cur_prio),
        .irq_o(irq_o), .vec_o(irq_vec_o)
    );

    // R1
    req_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|req_q, 2));
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  periph = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [8:0]  vec;
    int total = 0;
    int bad = 0;
    logic [3:0] psh [16];

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .periph_req_i(periph), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .irq_o(irq), .irq_vec_o(vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a; #0.5;
        check(req, rdata, exp);
    endtask

    task automatic set_prio(input int s, input logic [3:0] p);
        int w;
        psh[s] = p;
        w = s / 4;
        wr(6'(4 + w), {4'h0, psh[w*4+3], 4'h0, psh[w*4+2], 4'h0, psh[w*4+1], 4'h0, psh[w*4]});
    endtask

    task automatic clear_all();
        periph = '0;
        wr(6'd0, 32'h01010101);
        wr(6'd1, 32'h01010101);
        wr(6'd2, 32'h0);
        for (int s = 0; s < 16; s++) psh[s] = '0;
        for (int w = 0; w < 4; w++) wr(6'(4 + w), 32'h0);
        step(6);
    endtask

    task automatic t_reset();
        check("R10 irq", {31'b0, irq}, 32'h0);
        rd_chk("R10 sw flags", 6'd0, 32'h0);
        rd_chk("R10 cur prio", 6'd2, 32'h0);
        rd_chk("R10 prio", 6'd5, 32'h0);
    endtask

    task automatic t_layout();
        wr(6'd4, 32'hA5F3_1202);
        rd_chk("R11 nibble per byte", 6'd4, 32'h0503_0202);
        wr(6'd4, 32'h0);
    endtask

    task automatic t_periph();
        set_prio(8, 4'd3);
        periph[0] = 1'b1;
        step(2); check("R1 not before 3", {31'b0, irq}, 32'h0);
        step(1); check("R1 high at 3", {31'b0, irq}, 32'h1);
        check("R4 periph0 vector", {23'b0, vec}, 32'd8);
        periph[0] = 1'b0;
        step(2); check("R1 still high", {31'b0, irq}, 32'h1);
        step(1); check("R1 low at 3", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_sw();
        set_prio(2, 4'd5);
        wr(6'd0, 32'h0002_0000);
        rd_chk("R3 flag read, SET reads 0", 6'd0, 32'h0001_0000);
        step(2); check("R2 not before 4", {31'b0, irq}, 32'h0);
        step(1); check("R2 high at 4", {31'b0, irq}, 32'h1);
        check("R4 sw2 vector", {23'b0, vec}, 32'd2);
        wr(6'd0, 32'h0);
        rd_chk("R3 zero write ignored", 6'd0, 32'h0001_0000);
        check("R3 irq kept", {31'b0, irq}, 32'h1);
        wr(6'd0, 32'h0001_0000);
        rd_chk("R3 clear", 6'd0, 32'h0);
        step(2); check("R3 irq until flush", {31'b0, irq}, 32'h1);
        step(1); check("R3 irq drops", {31'b0, irq}, 32'h0);
        wr(6'd1, 32'h0300_0000);
        rd_chk("R3 set wins", 6'd1, 32'h0100_0000);
        clear_all();
    endtask

    task automatic t_priority();
        set_prio(1, 4'd2); set_prio(3, 4'd6); set_prio(9, 4'd4);
        wr(6'd0, 32'h0200_0200);
        periph[1] = 1'b1;
        step(6);
        check("R5 highest wins", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd3});
        clear_all();
        set_prio(5, 4'd7); set_prio(6, 4'd7);
        wr(6'd1, 32'h0002_0200);
        step(6);
        check("R6 tie lowest vector", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd5});
        clear_all();
        set_prio(7, 4'd9); set_prio(10, 4'd9);
        periph[2] = 1'b1;
        wr(6'd1, 32'h0200_0000);
        step(6);
        check("R6 sw vs periph tie", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd7});
        clear_all();
    endtask

    task automatic t_current();
        set_prio(12, 4'd7);
        wr(6'd2, 32'd7);
        periph[4] = 1'b1;
        step(6);
        check("R7 equal not forwarded", {31'b0, irq}, 32'h0);
        wr(6'd2, 32'd6);
        step(1);
        check("R8 lower cur takes effect", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd12});
        wr(6'd2, 32'd7);
        check("R8 one edge after write", {31'b0, irq}, 32'h1);
        step(1);
        check("R8 masked at second edge", {31'b0, irq}, 32'h0);
        clear_all();
        periph[5] = 1'b1;
        step(6);
        check("R7 priority 0 masked", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_handover();
        logic prev_irq;
        logic [8:0] prev_vec;
        set_prio(8, 4'd3); set_prio(9, 4'd5);
        periph[0] = 1'b1;
        step(5);
        check("R9 first vector", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd8});
        periph[1] = 1'b1;
        step(2);
        check("R9 held before switch", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd8});
        step(1);
        check("R9 gap cycle", {31'b0, irq}, 32'h0);
        step(1);
        check("R9 new vector", {22'b0, irq, vec}, {22'b0, 1'b1, 9'd9});
        prev_irq = irq; prev_vec = vec;
        for (int k = 0; k < 6; k++) begin
            step(1);
            if (irq && prev_irq) check("R9 stable while high", {23'b0, vec}, {23'b0, prev_vec});
            prev_irq = irq; prev_vec = vec;
        end
        clear_all();
    endtask

    initial begin
        for (int s = 0; s < 16; s++) psh[s] = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_layout();
        t_periph();
        t_sw();
        t_priority();
        t_current();
        t_handover();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule